// File: doc/BRIEF.md
# Two-Contestant Buzzer with LED Shot Animation

This block settles which of two contestants presses a button first and then plays a short animation on a row of four LEDs. A two-bit capture state both lights the winner lamps and selects how the LED register moves. Once a win or tie is captured, an internal step counter runs through eight steps. During a win it supplies the bit shifted into the LED register. During a tie it supplies the value loaded into every LED.

The host uses a ready strobe to re-arm the block for the next question. That strobe returns the capture state to idle, blanks the LEDs and rewinds the step counter. If it arrives in the middle of an animation, the animation stops at once. Button debouncing and clock division are handled elsewhere.

Top module: `buzzer_show`

## Requirements
- R1: The winner lamps always equal the two-bit capture state {winLamp1, winLamp0}. The codes are: idle 00, contestant 0 first 01, contestant 1 first 10, tie 11.
- R2: In idle, with hostReady low, the next state equals {btn1, btn0}. Both buttons high on the same edge gives the tie code 11. No buttons leaves the block idle.
- R3: In any non-idle state, the state holds whatever the buttons do, until hostReady is sampled high.
- R4: hostReady sampled high forces the next state to idle, clears ledPath to 0000 and rewinds the step counter. It has priority over button presses and over an animation step in the same cycle.
- R5: After synchronous reset, the lamps read 00 and ledPath reads 0000.
- R6: After a capture of contestant 0, ledPath starts on the following edge and shows 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 on successive cycles. Each pattern is the previous one shifted toward bit 3, with a new bit entering at bit 0.
- R7: After a capture of contestant 1, ledPath shows 1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000 on successive cycles. Each pattern is the previous one shifted toward bit 0, with a new bit entering at bit 3.
- R8: After a tie capture, ledPath alternates 1111 and 0000 for eight cycles, starting with 1111.
- R9: After the eighth pattern, ledPath stays 0000 and the lamps keep the winner until hostReady. The next capture replays the full eight-step sequence from its first pattern.
- R10: While the state is idle, ledPath stays 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hostReady | input | 1 | Re-arm strobe from the host |
| btn0 | input | 1 | Contestant 0 button, already debounced |
| btn1 | input | 1 | Contestant 1 button, already debounced |
| winLamp0 | output | 1 | Lamp for contestant 0 (state bit 0) |
| winLamp1 | output | 1 | Lamp for contestant 1 (state bit 1) |
| ledPath | output | 4 | Shot-animation LED row |

## Verification
Two events can fall in the same cycle: the host re-arm strobe and the final animation step, when the counter wraps and the done flag would set. The bench runs a contestant-0 animation up to its seventh pattern. It then raises hostReady together with the other contestant's button on the edge that would produce the eighth pattern. It checks that the block goes idle with dark LEDs rather than completing the step or capturing the press. A fresh capture afterwards must replay the other contestant's sequence from its first pattern, which shows the counter was rewound rather than left wrapping.

// File: rtl/buzzer_pkg.sv
package buzzer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WIN0 = 2'b01,
    ST_WIN1 = 2'b10,
    ST_TIE  = 2'b11
  } capState_t;

  typedef struct packed {
    logic clear;
    logic shiftUp;
    logic shiftDown;
    logic loadAll;
    logic fillBit;
  } pathCtrl_t;
endpackage

// File: rtl/buzzer_ctrl.sv
module buzzer_ctrl
  import buzzer_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hostReady,
  input  logic      btn0,
  input  logic      btn1,
  output capState_t state,
  output pathCtrl_t ctrl
);
  localparam int CNT_W = STEP_W + 1;
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1) << STEP_W;
  localparam logic [CNT_W-1:0] CNT_LAST  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] stepCnt;
  logic             done;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst || hostReady) begin
      state   <= ST_IDLE;
      stepCnt <= CNT_START;
      done    <= 1'b0;
    end else if (state == ST_IDLE) begin
      state <= capState_t'({btn1, btn0});
    end else if (!done) begin
      if (stepCnt == CNT_LAST) begin
        stepCnt <= CNT_START;
        done    <= 1'b1;
      end else begin
        stepCnt <= stepCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    active         = (state != ST_IDLE) && !done && !hostReady;
    ctrl.clear     = hostReady;
    ctrl.shiftUp   = active && (state == ST_WIN0);
    ctrl.shiftDown = active && (state == ST_WIN1);
    ctrl.loadAll   = active && (state == ST_TIE);
    ctrl.fillBit   = (state == ST_TIE) ? ~stepCnt[0] : ~stepCnt[STEP_W-1];
  end
endmodule

// File: rtl/buzzer_path.sv
module buzzer_path
  import buzzer_pkg::*;
#(
  parameter int LED_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  pathCtrl_t        ctrl,
  output logic [LED_W-1:0] leds
);
  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      leds <= '0;
    end else if (ctrl.shiftUp) begin
      leds <= {leds[LED_W-2:0], ctrl.fillBit};
    end else if (ctrl.shiftDown) begin
      leds <= {ctrl.fillBit, leds[LED_W-1:1]};
    end else if (ctrl.loadAll) begin
      leds <= {LED_W{ctrl.fillBit}};
    end
  end
endmodule

// File: rtl/buzzer_show.sv
module buzzer_show
  import buzzer_pkg::*;
#(
  parameter int LED_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hostReady,
  input  logic             btn0,
  input  logic             btn1,
  output logic             winLamp0,
  output logic             winLamp1,
  output logic [LED_W-1:0] ledPath
);
  capState_t state;
  pathCtrl_t ctrl;

  buzzer_ctrl #(.STEP_W(STEP_W)) uCtrl (
    .clk(clk), .rst(rst), .hostReady(hostReady),
    .btn0(btn0), .btn1(btn1), .state(state), .ctrl(ctrl)
  );

  buzzer_path #(.LED_W(LED_W)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .leds(ledPath)
  );

  assign winLamp0 = state[0];
  assign winLamp1 = state[1];
endmodule

// File: rtl/buzzer_show_checker.sv
module buzzer_show_checker #(
  parameter int LED_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hostReady,
  input logic             btn0,
  input logic             btn1,
  input logic             winLamp0,
  input logic             winLamp1,
  input logic [LED_W-1:0] ledPath
);
  logic [1:0] lamps;
  assign lamps = {winLamp1, winLamp0};

  assert_idle_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (lamps == 2'b00 && !hostReady) |=> lamps == $past({btn1, btn0}));

  assert_hold_winner_R3: assert property (@(posedge clk) disable iff (rst)
    (lamps != 2'b00 && !hostReady) |=> $stable(lamps));

  assert_rearm_R4: assert property (@(posedge clk) disable iff (rst)
    hostReady |=> (lamps == 2'b00 && ledPath == '0));

  assert_idle_dark_R10: assert property (@(posedge clk) disable iff (rst)
    (lamps == 2'b00) |-> ledPath == '0);

  assert_win0_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (lamps == 2'b01 && !hostReady) |=> ledPath[LED_W-1:1] == $past(ledPath[LED_W-2:0]));

  assert_win1_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (lamps == 2'b10 && !hostReady) |=> ledPath[LED_W-2:0] == $past(ledPath[LED_W-1:1]));

  assert_tie_uniform_R8: assert property (@(posedge clk) disable iff (rst)
    (lamps == 2'b11) |-> (ledPath == '0 || ledPath == '1));
endmodule

bind buzzer_show buzzer_show_checker #(.LED_W(LED_W)) uChecker (
  .clk(clk), .rst(rst), .hostReady(hostReady), .btn0(btn0), .btn1(btn1),
  .winLamp0(winLamp0), .winLamp1(winLamp1), .ledPath(ledPath)
);

// File: tb/tb_buzzer_show.sv
module tb_buzzer_show;
  logic clk = 1'b0;
  logic rst, hostReady, btn0, btn1;
  logic winLamp0, winLamp1;
  logic [3:0] ledPath;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  buzzer_show dut (
    .clk(clk), .rst(rst), .hostReady(hostReady), .btn0(btn0), .btn1(btn1),
    .winLamp0(winLamp0), .winLamp1(winLamp1), .ledPath(ledPath)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] win0Pat(input int i);
    if (i < 4) return 4'((1 << (i + 1)) - 1);
    return 4'(4'hF << (i - 3));
  endfunction

  function automatic logic [3:0] win1Pat(input int i);
    logic [3:0] p;
    p = win0Pat(i);
    return {p[0], p[1], p[2], p[3]};
  endfunction

  function automatic logic [3:0] tiePat(input int i);
    return (i % 2 == 0) ? 4'hF : 4'h0;
  endfunction

  task automatic rearm();
    hostReady = 1'b1;
    @(negedge clk);
    hostReady = 1'b0;
    check("R4 rearm lamps", {2'b00, winLamp1, winLamp0}, 4'b0000);
    check("R4 rearm leds", ledPath, 4'b0000);
  endtask

  // kind: 1 = contestant 0, 2 = contestant 1, 3 = tie
  task automatic playRound(input int kind);
    logic [3:0] exp;
    {btn1, btn0} = 2'(kind);
    @(negedge clk);
    {btn1, btn0} = 2'b00;
    check("R1 R2 capture lamps", {2'b00, winLamp1, winLamp0}, 4'(kind));
    check("R10 leds dark at capture", ledPath, 4'b0000);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {btn1, btn0} = 2'(3 - kind);
      exp = (kind == 1) ? win0Pat(i) : (kind == 2) ? win1Pat(i) : tiePat(i);
      check(kind == 1 ? "R6 win0 step" : kind == 2 ? "R7 win1 step" : "R8 tie step",
            ledPath, exp);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 hold dark after end", ledPath, 4'b0000);
      check("R3 lamps hold", {2'b00, winLamp1, winLamp0}, 4'(kind));
    end
    {btn1, btn0} = 2'b00;
  endtask

  task automatic testReset();
    rst = 1'b1; hostReady = 1'b0; btn0 = 1'b0; btn1 = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R5 reset lamps", {2'b00, winLamp1, winLamp0}, 4'b0000);
    check("R5 reset leds", ledPath, 4'b0000);
    repeat (3) @(negedge clk);
    check("R2 R10 idle without press", {winLamp1, winLamp0, 2'b00} | ledPath, 4'b0000);
  endtask

  task automatic testRearmPriority();
    {btn1, btn0} = 2'b11;
    hostReady = 1'b1;
    @(negedge clk);
    hostReady = 1'b0;
    {btn1, btn0} = 2'b00;
    check("R4 ready beats press", {2'b00, winLamp1, winLamp0}, 4'b0000);
  endtask

  task automatic testCollision();
    btn0 = 1'b1;
    @(negedge clk);
    btn0 = 1'b0;
    for (int i = 0; i < 7; i++) @(negedge clk);
    check("R6 seventh pattern", ledPath, 4'b1000);
    hostReady = 1'b1; btn1 = 1'b1;
    @(negedge clk);
    hostReady = 1'b0; btn1 = 1'b0;
    check("R4 collision lamps", {2'b00, winLamp1, winLamp0}, 4'b0000);
    check("R4 collision leds", ledPath, 4'b0000);
    playRound(2);
    rearm();
  endtask

  initial begin
    testReset();
    playRound(1);
    rearm();
    playRound(2);
    rearm();
    playRound(3);
    rearm();
    playRound(1);
    rearm();
    testRearmPriority();
    testCollision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule